// File: doc/BRIEF.md
# Video Input Timing Analyzer

This block sits on a parallel video input and works out its timing: the horizontal sync, the vertical sync and the data-enable line. Sync pulse widths and horizontal porches are counted in pixel clocks. Vertical porches and the vertical sync width are counted in lines. The block also measures the active width and height and decides the polarity of each sync line. A set of shadow registers holds the results. That set is refreshed only when a vertical sync begins, so a reader always sees the values of one complete frame.

A second, free-running reference clock drives the status side. Over a window of `REF_KHZ` reference cycles, the block counts pixel clock edges. That window is one millisecond when `REF_KHZ` equals the reference frequency in kHz, so the count is the pixel clock frequency in kHz. A watchdog on the reference side flags a stopped pixel clock. A stream is reported only while the pixel clock runs and data-enable keeps toggling.

Timing values and polarity codes belong to the pixel clock domain. The frequency, clock-alive and stream flags belong to the reference clock domain.

Top module: `vid_timing_meter`

## Requirements
- R1: `hs_pol` and `vs_pol` each carry a 2-bit code: 0 means active low, 1 means active high, 2 means not available.
  - The shorter of the last complete high run and the last complete low run is taken as the pulse, and its level gives the code.
  - The code is 2 until three edges have been seen since reset.
  - The code returns to 2 when the line shows no edge for `HS_TMO` (horizontal) or `VS_TMO` (vertical) pixel clocks.
- R2: `hs_width` is the number of pixel clocks for which the horizontal sync is at its active level.
- R3: `h_back` is the number of pixel clocks from the end of the horizontal sync pulse to the first data-enable pixel of that line.
- R4: `h_front` is the number of pixel clocks from the last data-enable pixel of a line to the next horizontal sync assertion.
- R5: `act_width` is the number of consecutive data-enable pixels in a line.
- R6: `act_height` is the number of lines per frame that contain data-enable.
- R7: `vs_width` is the number of horizontal sync assertions that fall inside the vertical sync pulse, including one coincident with its start.
- R8: Vertical porches are counted in lines.
  - `v_back` counts the lines without data-enable between the end of the vertical sync and the first active line.
  - `v_front` counts the lines without data-enable between the last active line and the next vertical sync assertion.
- R9: The eight timing outputs change only on the cycle after a vertical sync assertion, and only while both polarity codes are valid. They then describe the frame that just ended.
- R10: `pclk_khz` is the number of pixel clock edges counted over one window of `REF_KHZ` reference clocks, to within two counts.
- R11: If the pixel clock shows no activity for `ALIVE_TMO` reference clocks, `pclk_alive` goes to 0 and `pclk_khz` reads 0. Both recover once the clock runs again.
- R12: `stream_ok` is 1 only while the pixel clock is alive and data-enable has toggled within the last `DE_TMO` pixel clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_pix | input | 1 | Pixel clock of the video input |
| hs_in | input | 1 | Horizontal sync, either polarity |
| vs_in | input | 1 | Vertical sync, either polarity |
| de_in | input | 1 | Data enable, active high |
| clk_ref | input | 1 | Free-running reference clock |
| act_width | output | CW | Active pixels per line (shadowed) |
| act_height | output | CW | Active lines per frame (shadowed) |
| hs_width | output | CW | Horizontal sync width in pixel clocks (shadowed) |
| h_back | output | CW | Horizontal back porch in pixel clocks (shadowed) |
| h_front | output | CW | Horizontal front porch in pixel clocks (shadowed) |
| vs_width | output | CW | Vertical sync width in lines (shadowed) |
| v_back | output | CW | Vertical back porch in lines (shadowed) |
| v_front | output | CW | Vertical front porch in lines (shadowed) |
| hs_pol | output | 2 | Horizontal sync polarity code |
| vs_pol | output | 2 | Vertical sync polarity code |
| pclk_khz | output | FW | Pixel clock edges per reference window |
| pclk_alive | output | 1 | Pixel clock seen running |
| stream_ok | output | 1 | Stream detected |

## Verification
The assertions check four properties on every cycle:
- A polarity code never takes the unused value 3.
- The shadowed timing set holds still except on the cycle after a qualified vertical sync start.
- A dead pixel clock forces the frequency to zero on the next reference cycle.
- The stream flag is never raised without a live clock.

Only the bench's scenarios can show that the numbers are correct. It drives frames of two different geometries and both sync polarities, changes the line width in the middle of a frame, silences the inputs, and stops and restarts the pixel clock. Against each of these it compares porch, width, height, polarity and frequency values worked out from the stimulus.

// File: rtl/vid_timing_meter.sv
`timescale 1ns/1ps
module vid_timing_meter #(
  parameter int CW        = 12,
  parameter int RW        = 20,
  parameter int FW        = 20,
  parameter int HS_TMO    = 4096,
  parameter int VS_TMO    = 1000000,
  parameter int DE_TMO    = 1000000,
  parameter int REF_KHZ   = 100000,
  parameter int ALIVE_TMO = 1000
) (
  input  logic          rst_n,
  input  logic          clk_pix,
  input  logic          hs_in,
  input  logic          vs_in,
  input  logic          de_in,
  input  logic          clk_ref,
  output logic [CW-1:0] act_width,
  output logic [CW-1:0] act_height,
  output logic [CW-1:0] hs_width,
  output logic [CW-1:0] h_back,
  output logic [CW-1:0] h_front,
  output logic [CW-1:0] vs_width,
  output logic [CW-1:0] v_back,
  output logic [CW-1:0] v_front,
  output logic [1:0]    hs_pol,
  output logic [1:0]    vs_pol,
  output logic [FW-1:0] pclk_khz,
  output logic          pclk_alive,
  output logic          stream_ok
);
  localparam int WW = $clog2(REF_KHZ);
  localparam int AW = $clog2(ALIVE_TMO + 1);

  logic [1:0] sync_raw, sync_q;
  logic       de_q;
  logic [1:0] pol_c [2];

  assign sync_raw = {vs_in, hs_in};

  always_ff @(posedge clk_pix or negedge rst_n)
    if (!rst_n) begin
      sync_q <= '0;
      de_q   <= 1'b0;
    end else begin
      sync_q <= sync_raw;
      de_q   <= de_in;
    end

  for (genvar g = 0; g < 2; g++) begin : g_pol
    localparam int TMO = (g == 0) ? HS_TMO : VS_TMO;
    logic [RW-1:0] run_c, hi_len, lo_len;
    logic [1:0]    edges;
    always_ff @(posedge clk_pix or negedge rst_n)
      if (!rst_n) begin
        run_c <= '0; hi_len <= '0; lo_len <= '0; edges <= '0;
      end else if (sync_raw[g] != sync_q[g]) begin
        run_c <= RW'(1);
        if (sync_q[g]) hi_len <= run_c;
        else           lo_len <= run_c;
        if (edges != 2'd3) edges <= edges + 2'd1;
      end else if (run_c == RW'(TMO)) begin
        edges <= '0;
      end else begin
        run_c <= run_c + 1'b1;
      end
    assign pol_c[g] = (edges != 2'd3) ? 2'd2 : (hi_len < lo_len) ? 2'd1 : 2'd0;
  end

  assign hs_pol = pol_c[0];
  assign vs_pol = pol_c[1];

  logic hs_a, hs_aq, vs_a, vs_aq;
  logic hs_rise, hs_fall, vs_rise, vs_fall, de_rise, de_fall, vs_start;
  assign hs_a     = hs_in     ^ (hs_pol == 2'd0);
  assign hs_aq    = sync_q[0] ^ (hs_pol == 2'd0);
  assign vs_a     = vs_in     ^ (vs_pol == 2'd0);
  assign vs_aq    = sync_q[1] ^ (vs_pol == 2'd0);
  assign hs_rise  = hs_a & ~hs_aq;
  assign hs_fall  = ~hs_a & hs_aq;
  assign vs_rise  = vs_a & ~vs_aq;
  assign vs_fall  = ~vs_a & vs_aq;
  assign de_rise  = de_in & ~de_q;
  assign de_fall  = ~de_in & de_q;
  assign vs_start = vs_rise & ~hs_pol[1] & ~vs_pol[1];

  logic [CW-1:0] hw_c, s_hs, s_de, de_run, vw_c, vbp_c, vfp_c, lines_c, vfp_n;
  logic [CW-1:0] m_hsw, m_hbp, m_hfp, m_wid, m_vsw, m_vbp;
  logic          had_de, vbp_arm;

  assign vfp_n = de_in ? '0 : (hs_rise & ~had_de) ? vfp_c + 1'b1 : vfp_c;

  always_ff @(posedge clk_pix or negedge rst_n)
    if (!rst_n) begin
      {hw_c, s_hs, s_de, de_run, vw_c, vbp_c, vfp_c, lines_c} <= '0;
      {m_hsw, m_hbp, m_hfp, m_wid, m_vsw, m_vbp} <= '0;
      {act_width, act_height, hs_width, h_back, h_front, vs_width, v_back, v_front} <= '0;
      had_de  <= 1'b0;
      vbp_arm <= 1'b0;
    end else begin
      hw_c   <= hs_rise ? CW'(1) : hs_a ? hw_c + 1'b1 : hw_c;
      s_hs   <= hs_a  ? '0 : s_hs + 1'b1;
      s_de   <= de_in ? '0 : s_de + 1'b1;
      de_run <= de_rise ? CW'(1) : de_in ? de_run + 1'b1 : de_run;
      had_de <= hs_rise ? de_in : (had_de | de_in);
      vfp_c  <= vfp_n;
      if (hs_fall)           m_hsw <= hw_c;
      if (de_rise)           m_hbp <= s_hs;
      if (hs_rise && had_de) m_hfp <= s_de;
      if (de_fall)           m_wid <= de_run;
      if (vs_rise)                vw_c <= hs_rise ? CW'(1) : '0;
      else if (vs_a && hs_rise)   vw_c <= vw_c + 1'b1;
      if (vs_fall)           m_vsw <= vw_c;
      if (vs_fall) begin
        vbp_c   <= '0;
        vbp_arm <= 1'b1;
      end else begin
        if (hs_rise && !had_de) vbp_c <= vbp_c + 1'b1;
        if (de_rise && vbp_arm) begin
          m_vbp   <= vbp_c;
          vbp_arm <= 1'b0;
        end
      end
      lines_c <= vs_rise ? '0 : de_rise ? lines_c + 1'b1 : lines_c;
      if (vs_start) begin
        act_width  <= m_wid;
        act_height <= lines_c;
        hs_width   <= m_hsw;
        h_back     <= m_hbp;
        h_front    <= m_hfp;
        vs_width   <= m_vsw;
        v_back     <= m_vbp;
        v_front    <= vfp_n;
      end
    end

  logic [RW-1:0] de_qc;
  logic [2:0]    pdiv, rq;
  logic [FW-1:0] pcnt, hold;
  logic          ack_t;

  always_ff @(posedge clk_pix or negedge rst_n)
    if (!rst_n) begin
      de_qc <= RW'(DE_TMO);
      pdiv  <= '0;
      rq    <= '0;
      pcnt  <= '0;
      hold  <= '0;
      ack_t <= 1'b0;
    end else begin
      if (de_in != de_q)              de_qc <= '0;
      else if (de_qc != RW'(DE_TMO))  de_qc <= de_qc + 1'b1;
      pdiv <= pdiv + 1'b1;
      rq   <= {rq[1:0], req_t};
      if (rq[2] ^ rq[1]) begin
        hold  <= pcnt;
        pcnt  <= FW'(1);
        ack_t <= ~ack_t;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end

  logic [WW-1:0] win_c;
  logic [AW-1:0] quiet, quiet_n;
  logic [2:0]    ak, tg;
  logic [1:0]    ds;
  logic          req_t;

  assign quiet_n = (tg[2] ^ tg[1]) ? '0 : (quiet == AW'(ALIVE_TMO)) ? quiet : quiet + 1'b1;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      win_c      <= '0;
      req_t      <= 1'b0;
      ak         <= '0;
      tg         <= '0;
      ds         <= '0;
      quiet      <= AW'(ALIVE_TMO);
      pclk_alive <= 1'b0;
      stream_ok  <= 1'b0;
      pclk_khz   <= '0;
    end else begin
      if (win_c == WW'(REF_KHZ - 1)) begin
        win_c <= '0;
        if (req_t == ak[1]) req_t <= ~req_t;
      end else begin
        win_c <= win_c + 1'b1;
      end
      ak         <= {ak[1:0], ack_t};
      tg         <= {tg[1:0], pdiv[2]};
      ds         <= {ds[0], de_qc != RW'(DE_TMO)};
      quiet      <= quiet_n;
      pclk_alive <= quiet_n != AW'(ALIVE_TMO);
      stream_ok  <= (quiet_n != AW'(ALIVE_TMO)) & ds[1];
      if (!pclk_alive)         pclk_khz <= '0;
      else if (ak[2] ^ ak[1])  pclk_khz <= hold;
    end
endmodule

module vid_timing_meter_chk #(
  parameter int CW = 12,
  parameter int FW = 20
) (
  input logic          rst_n,
  input logic          clk_pix,
  input logic          clk_ref,
  input logic          vs_start,
  input logic [1:0]    hs_pol,
  input logic [1:0]    vs_pol,
  input logic [8*CW-1:0] shadow,
  input logic [FW-1:0] pclk_khz,
  input logic          pclk_alive,
  input logic          stream_ok
);
  AST_POL_CODE: assert property (@(posedge clk_pix) disable iff (!rst_n)
    (hs_pol != 2'd3) && (vs_pol != 2'd3)); // R1
  AST_SHADOW_HOLD: assert property (@(posedge clk_pix) disable iff (!rst_n)
    !vs_start |=> $stable(shadow)); // R9
  AST_DEAD_ZERO: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !pclk_alive |=> pclk_khz == '0); // R11
  AST_STREAM_LIVE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    stream_ok |-> pclk_alive); // R12
endmodule

bind vid_timing_meter vid_timing_meter_chk #(.CW(CW), .FW(FW)) u_chk (
  .rst_n(rst_n), .clk_pix(clk_pix), .clk_ref(clk_ref), .vs_start(vs_start),
  .hs_pol(hs_pol), .vs_pol(vs_pol),
  .shadow({act_width, act_height, hs_width, h_back, h_front, vs_width, v_back, v_front}),
  .pclk_khz(pclk_khz), .pclk_alive(pclk_alive), .stream_ok(stream_ok));

// File: tb/test_vid_timing_meter.sv
`timescale 1ns/1ps
module test_vid_timing_meter;
  localparam int CW = 12;
  localparam int FW = 20;

  logic rst_n, clk_pix, clk_ref, hs_in, vs_in, de_in;
  logic [CW-1:0] act_width, act_height, hs_width, h_back, h_front, vs_width, v_back, v_front;
  logic [1:0] hs_pol, vs_pol;
  logic [FW-1:0] pclk_khz;
  logic pclk_alive, stream_ok;

  vid_timing_meter #(.CW(CW), .FW(FW), .HS_TMO(200), .VS_TMO(2000), .DE_TMO(2000),
                     .REF_KHZ(500), .ALIVE_TMO(64)) i_vid_timing_meter (.*);

  int errs = 0, checks = 0;
  bit done = 0;
  bit pclk_en = 1;
  int pix_half = 5;
  int hsw, hbp, aw, hfp, vsw, vbp, ah, vfp;
  logic hpol, vpol;

  initial clk_ref = 0;
  always #2 clk_ref = ~clk_ref;
  initial clk_pix = 0;
  always begin
    #(pix_half);
    if (pclk_en) clk_pix = ~clk_pix;
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: got hang expected completion");
      report();
    end
  end

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input longint got,
                         input longint lo, input longint hi);
    checks++;
    if (got < lo || got > hi) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d..%0d", req, what, got, lo, hi);
    end
  endtask

  task automatic pix(input logic h, input logic v, input logic d);
    @(negedge clk_pix);
    hs_in = h; vs_in = v; de_in = d;
  endtask

  task automatic do_line(input bit vact, input bit dact);
    logic v;
    v = vact ? vpol : ~vpol;
    repeat (hsw) pix(hpol, v, 1'b0);
    repeat (hbp) pix(~hpol, v, 1'b0);
    repeat (aw)  pix(~hpol, v, dact);
    repeat (hfp) pix(~hpol, v, 1'b0);
  endtask

  task automatic run_frames(input int n);
    repeat (n) begin
      repeat (vsw) do_line(1, 0);
      repeat (vbp) do_line(0, 0);
      repeat (ah)  do_line(0, 1);
      repeat (vfp) do_line(0, 0);
    end
  endtask

  task automatic check_geometry(input string tag, input logic [1:0] hp, input logic [1:0] vp);
    repeat (3) @(negedge clk_pix);
    chk("R1", {tag, " hs_pol"}, hs_pol, hp);
    chk("R1", {tag, " vs_pol"}, vs_pol, vp);
    chk("R2", {tag, " hs_width"}, hs_width, hsw);
    chk("R3", {tag, " h_back"}, h_back, hbp);
    chk("R4", {tag, " h_front"}, h_front, hfp);
    chk("R5", {tag, " act_width"}, act_width, aw);
    chk("R6", {tag, " act_height"}, act_height, ah);
    chk("R7", {tag, " vs_width"}, vs_width, vsw);
    chk("R8", {tag, " v_back"}, v_back, vbp);
    chk("R8", {tag, " v_front"}, v_front, vfp);
  endtask

  task automatic test_reset();
    @(negedge clk_ref);
    chk("R11", "reset pclk_khz", pclk_khz, 0);
    chk("R11", "reset pclk_alive", pclk_alive, 0);
    chk("R12", "reset stream_ok", stream_ok, 0);
    chk("R1", "reset hs_pol", hs_pol, 2);
    chk("R1", "reset vs_pol", vs_pol, 2);
    chk("R9", "reset act_width", act_width, 0);
  endtask

  task automatic test_low_sync();
    pix_half = 5;
    hpol = 0; vpol = 0;
    hsw = 4; hbp = 6; aw = 20; hfp = 5;
    vsw = 2; vbp = 3; ah = 8; vfp = 2;
    run_frames(5);
    check_geometry("low", 2'd0, 2'd0);
    @(negedge clk_ref);
    chk_rng("R10", "khz at 10ns", pclk_khz, 198, 202);
    chk("R11", "alive while running", pclk_alive, 1);
    chk("R12", "stream during video", stream_ok, 1);
  endtask

  task automatic test_high_sync();
    pix_half = 8;
    hpol = 1; vpol = 1;
    hsw = 3; hbp = 2; aw = 12; hfp = 7;
    vsw = 1; vbp = 2; ah = 5; vfp = 4;
    run_frames(5);
    check_geometry("high", 2'd1, 2'd1);
    @(negedge clk_ref);
    chk_rng("R10", "khz at 16ns", pclk_khz, 123, 127);
  endtask

  task automatic test_shadow_hold();
    aw = 9;
    repeat (vsw) do_line(1, 0);
    repeat (vbp) do_line(0, 0);
    repeat (2)   do_line(0, 1);
    chk("R9", "act_width held mid-frame", act_width, 12);
    repeat (ah - 2) do_line(0, 1);
    repeat (vfp)    do_line(0, 0);
    run_frames(1);
    repeat (3) @(negedge clk_pix);
    chk("R9", "act_width after next vsync", act_width, 9);
    chk("R6", "act_height after width change", act_height, 5);
  endtask

  task automatic test_quiet_inputs();
    repeat (2500) @(negedge clk_pix);
    chk("R1", "hs_pol after silence", hs_pol, 2);
    chk("R1", "vs_pol after silence", vs_pol, 2);
    @(negedge clk_ref);
    chk("R12", "stream_ok without DE", stream_ok, 0);
    chk("R12", "clock still alive", pclk_alive, 1);
  endtask

  task automatic test_clock_stop();
    pclk_en = 0;
    repeat (200) @(negedge clk_ref);
    chk("R11", "alive after stop", pclk_alive, 0);
    chk("R11", "khz after stop", pclk_khz, 0);
    chk("R12", "stream after stop", stream_ok, 0);
    pclk_en = 1;
    pix_half = 5;
    hpol = 0; vpol = 0;
    hsw = 4; hbp = 6; aw = 20; hfp = 5;
    vsw = 2; vbp = 3; ah = 8; vfp = 2;
    run_frames(5);
    @(negedge clk_ref);
    chk("R11", "alive after restart", pclk_alive, 1);
    chk_rng("R11", "khz after restart", pclk_khz, 198, 202);
    chk("R12", "stream after restart", stream_ok, 1);
  endtask

  initial begin
    rst_n = 0; hs_in = 1; vs_in = 1; de_in = 0;
    repeat (10) @(negedge clk_ref);
    rst_n = 1;
    test_reset();
    test_low_sync();
    test_high_sync();
    test_shadow_hold();
    test_quiet_inputs();
    test_clock_stop();
    done = 1;
    report();
  end
endmodule